// File: doc/BRIEF.md
# Audio Interface Interrupt Aggregator

This block gathers single-cycle event pulses from the transmit, receive and rate-converter parts of an audio interface and turns them into one host interrupt. Events latch into an 8-bit status register. Each latched bit holds until the host reads that register, and the read clears it. A separate 3-bit enable register picks which converter error flags may set a summary bit at the top of the status register. The host then reads a second-level converter error register, which lives outside this block.

One status bit behaves differently. The receiver A/B channel-status mismatch bit latches and clears like the others, but it never drives the interrupt line. The host reaches both registers through a plain port with a 7-bit address, a write enable and a read strobe. Read data is registered and appears one cycle after the strobe.

Top module: `audio_irq_aggregator`

## Requirements
- R1: After a synchronous active-high reset, the status register, the enable register, `irq` and `host_rdata` are all 0.
- R2: A one-cycle high on an event input sets its status bit on the next clock edge, and the bit stays set while no clearing read occurs. Status bit map: 7 converter summary, 6 `tx_evt[2]` (status write collision), 5 `tx_evt[1]` (user buffer empty), 4 `tx_evt[0]` (status block sent), 3 `rx_evt[3]` (A/B status mismatch), 2 `rx_evt[2]` (user block ready), 1 `rx_evt[1]` (status changed), 0 `rx_evt[0]` (receiver error summary).
- R3: A read strobe at address 0x1C returns the status value held before that edge, and the same edge clears every status bit that has no set event in that cycle.
- R4: If an event and a clearing read hit the same bit in the same cycle, the bit is set after the edge. The read in that cycle returns the old value.
- R5: The enable register at address 0x1B keeps write data bits 2..0 (bit 2 left overrange, bit 1 right overrange, bit 0 mute indicator). Bits 7..3 read as 0 and writes to them are ignored. Reading it changes no state.
- R6: Status bit 7 sets on any cycle where some `cvt_err[i]` is high while enable bit i is 1. A converter flag whose enable bit is 0 leaves bit 7 unchanged.
- R7: `irq` is high exactly when at least one of status bits 7..4 or 2..0 is set. Status bit 3 alone keeps `irq` low.
- R8: After a status read that clears every contributing bit, `irq` is low in the following cycle.
- R9: A write to address 0x1C leaves the status register unchanged.
- R10: `host_rdata` updates one cycle after a read strobe and returns 0 for any address other than 0x1B and 0x1C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_addr | input | 7 | Register address |
| host_wdata | input | 8 | Write data |
| host_we | input | 1 | Write enable, one cycle per write |
| host_re | input | 1 | Read strobe, one cycle per read |
| host_rdata | output | 8 | Registered read data |
| tx_evt | input | 3 | Transmit event pulses (status bits 6..4) |
| rx_evt | input | 4 | Receive event pulses (status bits 3..0) |
| cvt_err | input | 3 | Converter error flags: 2 left overrange, 1 right overrange, 0 mute |
| irq | output | 1 | Interrupt, active high |

## Verification
The assertions take event inputs as sampled each cycle, with no assumption about pulse width. They expect read and write strobes never to share an address decode that matters to both. A write to the enable register and a status read in the same cycle must act independently. The stimulus drives every input on the falling clock edge and holds each strobe for exactly one cycle, so every rising edge sees stable, well-defined inputs. Same-cycle event-and-read collisions are produced on purpose only in the directed test for the set-wins rule.

// File: rtl/aai_pkg.sv
package aai_pkg;
  localparam int ADDR_W   = 7;
  localparam int DATA_W   = 8;
  localparam int TX_N     = 3;
  localparam int RX_N     = 4;
  localparam int CVT_N    = 3;
  localparam int STAT_W   = 1 + TX_N + RX_N;
  localparam logic [ADDR_W-1:0] EN_ADDR   = 7'h1B;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 7'h1C;
  // receiver A/B mismatch is the top receiver bit; it never drives irq
  localparam int QUIET_BIT = RX_N - 1;
  localparam logic [STAT_W-1:0] IRQ_SEL = ~(STAT_W'(1) << QUIET_BIT);
endpackage

// File: rtl/aai_enable_reg.sv
module aai_enable_reg
  import aai_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int EN_N = CVT_N,
  parameter logic [AW-1:0] MY_ADDR = EN_ADDR
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [EN_N-1:0] en_q
);
  logic hit;
  logic unused_wdata_hi;

  assign hit = wr_en && (wr_addr == MY_ADDR);
  assign unused_wdata_hi = ^wr_data[DW-1:EN_N];

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else if (hit) en_q <= wr_data[EN_N-1:0];
  end

  a_r5_enable_holds: assert property (@(posedge clk) disable iff (rst)
    !hit |=> $stable(en_q));
  a_r5_enable_loads: assert property (@(posedge clk) disable iff (rst)
    hit |=> (en_q == $past(wr_data[EN_N-1:0])));
endmodule

// File: rtl/aai_sticky_bank.sv
module aai_sticky_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] bits_q,
  output logic [N-1:0] bits_nxt
);
  for (genvar k = 0; k < N; k++) begin : g_cell
    // set has priority over a clearing read in the same cycle
    assign bits_nxt[k] = set_i[k] | (bits_q[k] & ~clr_i);

    always_ff @(posedge clk) begin
      if (rst) bits_q[k] <= 1'b0;
      else     bits_q[k] <= bits_nxt[k];
    end

    a_r4_set_wins: assert property (@(posedge clk) disable iff (rst)
      set_i[k] |=> bits_q[k]);
    a_r3_read_clears: assert property (@(posedge clk) disable iff (rst)
      (clr_i && !set_i[k]) |=> !bits_q[k]);
    a_r2_sticky_hold: assert property (@(posedge clk) disable iff (rst)
      (!clr_i && bits_q[k]) |=> bits_q[k]);
  end
endmodule

// File: rtl/aai_read_port.sv
module aai_read_port
  import aai_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int SW = STAT_W,
  parameter int EW = CVT_N
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rd_addr,
  input  logic          rd_en,
  input  logic [SW-1:0] stat_q,
  input  logic [EW-1:0] en_q,
  output logic [DW-1:0] rdata_q
);
  logic [DW-1:0] sel;

  always_comb begin
    sel = '0;
    if (rd_addr == STAT_ADDR)    sel[SW-1:0] = stat_q;
    else if (rd_addr == EN_ADDR) sel[EW-1:0] = en_q;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= sel;
  end

  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr != STAT_ADDR && rd_addr != EN_ADDR) |=> (rdata_q == '0));
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata_q));
endmodule

// File: rtl/audio_irq_aggregator.sv
module audio_irq_aggregator
  import aai_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_we,
  input  logic              host_re,
  output logic [DATA_W-1:0] host_rdata,
  input  logic [TX_N-1:0]   tx_evt,
  input  logic [RX_N-1:0]   rx_evt,
  input  logic [CVT_N-1:0]  cvt_err,
  output logic              irq
);
  logic [CVT_N-1:0]  en_q;
  logic              cvt_hit;
  logic [STAT_W-1:0] set_vec;
  logic              stat_clr;
  logic [STAT_W-1:0] stat_q;
  logic [STAT_W-1:0] stat_nxt;
  logic              irq_q;

  aai_enable_reg u_enable (
    .clk(clk), .rst(rst),
    .wr_addr(host_addr), .wr_en(host_we), .wr_data(host_wdata),
    .en_q(en_q)
  );

  assign cvt_hit  = |(cvt_err & en_q);
  assign set_vec  = {cvt_hit, tx_evt, rx_evt};
  assign stat_clr = host_re && (host_addr == STAT_ADDR);

  aai_sticky_bank #(.N(STAT_W)) u_status (
    .clk(clk), .rst(rst),
    .set_i(set_vec), .clr_i(stat_clr),
    .bits_q(stat_q), .bits_nxt(stat_nxt)
  );

  aai_read_port u_read (
    .clk(clk), .rst(rst),
    .rd_addr(host_addr), .rd_en(host_re),
    .stat_q(stat_q), .en_q(en_q),
    .rdata_q(host_rdata)
  );

  // registered interrupt, computed from the next status value so it tracks stat_q
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(stat_nxt & IRQ_SEL);
  end
  assign irq = irq_q;

  a_r7_irq_tracks: assert property (@(posedge clk) disable iff (rst)
    irq == |(stat_q & IRQ_SEL));
  a_r6_summary_sets: assert property (@(posedge clk) disable iff (rst)
    (|(cvt_err & en_q)) |=> stat_q[STAT_W-1]);
  a_r8_irq_drops: assert property (@(posedge clk) disable iff (rst)
    (stat_clr && ((set_vec & IRQ_SEL) == '0)) |=> !irq);
  a_r9_status_write_inert: assert property (@(posedge clk) disable iff (rst)
    (host_we && host_addr == STAT_ADDR && !host_re && set_vec == '0)
      |=> (stat_q == $past(stat_q)));
  a_r5_enable_read_inert: assert property (@(posedge clk) disable iff (rst)
    (host_re && host_addr == EN_ADDR && !host_we) |=> $stable(en_q));
endmodule

// File: tb/audio_irq_aggregator_bench.sv
module audio_irq_aggregator_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic       host_we = 1'b0;
  logic       host_re = 1'b0;
  logic [7:0] host_rdata;
  logic [2:0] tx_evt = '0;
  logic [3:0] rx_evt = '0;
  logic [2:0] cvt_err = '0;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  audio_irq_aggregator u_audio_irq_aggregator (
    .clk(clk), .rst(rst),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .host_we(host_we), .host_re(host_re), .host_rdata(host_rdata),
    .tx_evt(tx_evt), .rx_evt(rx_evt), .cvt_err(cvt_err), .irq(irq)
  );

  // entry: tx[3] rx[4] cvt[3] enable[3] expected status[8] expected irq[1]
  localparam int NV = 7;
  localparam logic [21:0] VEC [NV] = '{
    {3'b100, 4'b0000, 3'b000, 3'b000, 8'h40, 1'b1},
    {3'b000, 4'b1000, 3'b000, 3'b000, 8'h08, 1'b0},
    {3'b000, 4'b0000, 3'b100, 3'b100, 8'h80, 1'b1},
    {3'b000, 4'b0000, 3'b011, 3'b100, 8'h00, 1'b0},
    {3'b011, 4'b0111, 3'b001, 3'b001, 8'hB7, 1'b1},
    {3'b001, 4'b1000, 3'b000, 3'b000, 8'h18, 1'b1},
    {3'b000, 4'b0000, 3'b010, 3'b111, 8'h80, 1'b1}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_we = 1'b1;
    @(negedge clk); host_we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [7:0] d);
    @(negedge clk); host_addr = a; host_re = 1'b1;
    @(negedge clk); host_re = 1'b0; d = host_rdata;
  endtask

  task automatic pulse(input logic [2:0] t, input logic [3:0] r, input logic [2:0] c);
    @(negedge clk); tx_evt = t; rx_evt = r; cvt_err = c;
    @(negedge clk); tx_evt = '0; rx_evt = '0; cvt_err = '0;
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", {7'd0, irq}, 8'h00);
    check("R1 rdata", host_rdata, 8'h00);
    rd(7'h1C, d); check("R1 status", d, 8'h00);
    rd(7'h1B, d); check("R1 enable", d, 8'h00);

    // table walk: R2 R3 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      logic [21:0] v;
      v = VEC[i];
      wr(7'h1B, {5'b0, v[11:9]});
      pulse(v[21:19], v[18:15], v[14:12]);
      @(negedge clk);
      check("R7 irq level", {7'd0, irq}, {7'd0, v[0]});
      rd(7'h1C, d);
      check("R2/R3/R6 status read", d, v[8:1]);
      check("R8 irq after clear", {7'd0, irq}, 8'h00);
      rd(7'h1C, d);
      check("R3 cleared", d, 8'h00);
    end

    // R2 hold over many cycles
    pulse(3'b000, 4'b0001, 3'b000);
    repeat (20) @(negedge clk);
    check("R2 held irq", {7'd0, irq}, 8'h01);
    rd(7'h1C, d); check("R2 held bit", d, 8'h01);

    // R4 set and read in the same cycle
    @(negedge clk); host_addr = 7'h1C; host_re = 1'b1; rx_evt = 4'b0100;
    @(negedge clk); host_re = 1'b0; rx_evt = '0;
    check("R4 read returns old", host_rdata, 8'h00);
    check("R4 irq stays", {7'd0, irq}, 8'h01);
    rd(7'h1C, d); check("R4 bit survived", d, 8'h04);

    // R5 reserved bits, read side effects
    wr(7'h1B, 8'hFF);
    rd(7'h1B, d); check("R5 reserved zero", d, 8'h07);
    wr(7'h1B, 8'hF8);
    rd(7'h1B, d); check("R5 upper write ignored", d, 8'h00);
    pulse(3'b010, 4'b0000, 3'b000);
    rd(7'h1B, d); rd(7'h1B, d);
    check("R5 enable read no side effect irq", {7'd0, irq}, 8'h01);
    rd(7'h1C, d); check("R5 status after enable reads", d, 8'h20);

    // R6 disabled flag held high leaves summary clear
    wr(7'h1B, 8'h03);
    @(negedge clk); cvt_err = 3'b100;
    repeat (4) @(negedge clk);
    cvt_err = '0;
    rd(7'h1C, d); check("R6 disabled flag", d, 8'h00);

    // R7 mismatch bit alone keeps irq low but is latched
    pulse(3'b000, 4'b1000, 3'b000);
    @(negedge clk);
    check("R7 quiet bit irq", {7'd0, irq}, 8'h00);
    rd(7'h1C, d); check("R7 quiet bit latched", d, 8'h08);

    // R9 write to status address
    pulse(3'b000, 4'b0010, 3'b000);
    wr(7'h1C, 8'h00);
    wr(7'h1C, 8'hFF);
    rd(7'h1C, d); check("R9 status write inert", d, 8'h02);
    wr(7'h1C, 8'hFF);
    rd(7'h1C, d); check("R9 write does not set", d, 8'h00);

    // R10 unmapped read and timing
    pulse(3'b100, 4'b0000, 3'b000);
    rd(7'h10, d); check("R10 unmapped", d, 8'h00);
    rd(7'h1D, d); check("R10 unmapped near", d, 8'h00);
    @(negedge clk); host_addr = 7'h1C; host_re = 1'b1;
    #1 check("R10 no early update", host_rdata, 8'h00);
    @(negedge clk); host_re = 1'b0;
    check("R10 one cycle later", host_rdata, 8'h40);

    // R1 reset mid-run clears everything
    wr(7'h1B, 8'h05);
    pulse(3'b111, 4'b1111, 3'b000);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 irq after reset", {7'd0, irq}, 8'h00);
    rd(7'h1C, d); check("R1 status after reset", d, 8'h00);
    rd(7'h1B, d); check("R1 enable after reset", d, 8'h00);

    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule